// File: doc/BRIEF.md
# DMA Transfer Submission Queue

This block is the register-side front end of a single-channel DMA engine. Software fills a set of staging registers with one transfer description: flags, two addresses, two lengths and two strides. It then writes the start register. The block stamps the description with a rolling 5-bit transfer ID and places it in a small queue. The queue feeds a downstream data mover over a valid/ready port, oldest entry first.

The mover reports each finished transfer by its ID. The block keeps one completion bit per ID and raises an interrupt for queue acceptance and for completion. Features that an instance leaves out read back as zero, so software can discover them. A device-side address, a missing second dimension and an unsupported cyclic flag all read zero. The X length register shows the largest supported length and the length granularity.

Top module: `dma_submit_queue`

## Requirements
- R1: After reset, control reads 0, the next-ID register reads 0, the interrupt mask reads 3 (both suppressed), pending and completion read 0, X length reads the alignment mask (3 by default), and `desc_valid` and `irq` are low.
- R2: Staging registers read back what was written. Flags keep bits [2:0]; bit 0 (cyclic) is kept only when cyclic support is built in. Lengths keep their low LEN_W bits (24 by default). X length always reads its low LEN_ALIGN_BITS bits as ones, so writing all ones reads 0x00FFFFFF and writing 0 reads 0x3.
- R3: The address and stride registers of a side that is not memory-mapped read 0, and the matching descriptor output field is 0. By default the destination side (0x410, 0x420) is the device side.
- R4: Writing 1 to 0x408 while enabled queues the staged registers under the ID shown at 0x404. The ID then steps by one and wraps from 31 to 0. Descriptors leave on the `desc_*` port in submission order.
- R5: The queue holds QDEPTH (4) descriptors. A start request made while it is full is held, and 0x408 reads 1 until a slot frees. The held request is then accepted on the following clock.
- R6: `desc_valid` is high only when the queue is non-empty, control bit 0 (enable) is 1 and control bit 1 (pause) is 0. Pausing keeps the queued descriptors.
- R7: While control bit 0 is 0, the queue is emptied. Descriptors queued before a disable are not offered after re-enabling.
- R8: Completion at 0x428 holds one bit per ID, set by `done_valid` for `done_id`. The bit clears when that ID is handed to a new submission. `done_partial` with `done_valid` sets bit 31, and writing 1 to bit 31 clears it.
- R9: Pending (0x84) bit 0 sets when a descriptor is accepted and bit 1 sets on each completion. Writing 1 to a bit clears it, but a new event in the same cycle wins over the clear.
- R10: Mask (0x80) bit 1 suppresses the matching interrupt. `irq` is the OR of the pending bits whose mask bit is 0, and 0x88 reads those unmasked pending bits.
- R11: A start write while control bit 0 is 0 is ignored: nothing is queued and the ID does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of `reg_addr`, combinational |
| desc_valid | output | 1 | Queue head offered to the mover |
| desc_ready | input | 1 | Mover takes the head |
| desc_id | output | 5 | Transfer ID of the head |
| desc_flags | output | 3 | Flags: cyclic, last, partial report |
| desc_dst | output | 32 | Destination address |
| desc_src | output | 32 | Source address |
| desc_xlen | output | 32 | X length minus one |
| desc_ylen | output | 32 | Y length minus one |
| desc_dstride | output | 32 | Destination stride |
| desc_sstride | output | 32 | Source stride |
| done_valid | input | 1 | Mover reports a finished transfer |
| done_id | input | 5 | ID of the finished transfer |
| done_partial | input | 1 | Finished transfer was shorter than programmed |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge it is presented on. Its readback, the mask-dependent `irq` and the enable/pause gating of `desc_valid` are therefore due one cycle later. A start write needs a second edge before the descriptor shows on the port, the ID steps and pending bit 0 sets. A completion input is visible in the completion and pending registers one cycle after it is presented. The bench drives every input on the falling edge and counts the rising edges each register on the path needs. It reads only at the falling edge that follows the last required rising edge. For the full-queue case it checks both the held state before a pop and the acceptance one edge after it.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
   localparam int ADDR_W  = 12;
   localparam int ID_W    = 5;
   localparam int NUM_IDS = 1 << ID_W;
   localparam int NUM_IRQ = 2;

   // register offsets; positions of fields software decodes are fixed
   localparam logic [ADDR_W-1:0] OFF_MASK    = 12'h080;
   localparam logic [ADDR_W-1:0] OFF_PEND    = 12'h084;
   localparam logic [ADDR_W-1:0] OFF_ACTIVE  = 12'h088;
   localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h400;
   localparam logic [ADDR_W-1:0] OFF_NEXTID  = 12'h404;
   localparam logic [ADDR_W-1:0] OFF_START   = 12'h408;
   localparam logic [ADDR_W-1:0] OFF_FLAGS   = 12'h40c;
   localparam logic [ADDR_W-1:0] OFF_DST     = 12'h410;
   localparam logic [ADDR_W-1:0] OFF_SRC     = 12'h414;
   localparam logic [ADDR_W-1:0] OFF_XLEN    = 12'h418;
   localparam logic [ADDR_W-1:0] OFF_YLEN    = 12'h41c;
   localparam logic [ADDR_W-1:0] OFF_DSTRIDE = 12'h420;
   localparam logic [ADDR_W-1:0] OFF_SSTRIDE = 12'h424;
   localparam logic [ADDR_W-1:0] OFF_DONE    = 12'h428;

   localparam int IRQ_ACCEPT = 0;
   localparam int IRQ_FINISH = 1;

   typedef struct packed {
      logic [ID_W-1:0] id;
      logic [2:0]      flags;
      logic [31:0]     dst;
      logic [31:0]     src;
      logic [31:0]     xlen;
      logic [31:0]     ylen;
      logic [31:0]     dstride;
      logic [31:0]     sstride;
   } dmaq_desc_t;
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
   parameter int DEPTH = 4,
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   if (DEPTH < 1 || DEPTH > 64) begin : g_bad_depth
      $error("dmaq_fifo: DEPTH out of range");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;

   assign full  = (count == FULL_CNT);
   assign empty = (count == '0);
   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
         if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> !full);
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt,
   input  logic            mask_we,
   input  logic [NSRC-1:0] mask_wdata,
   input  logic            clr_we,
   input  logic [NSRC-1:0] clr_wdata,
   output logic [NSRC-1:0] mask_q,
   output logic [NSRC-1:0] pend_q,
   output logic            irq
);
   if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
      $error("dmaq_irq: NSRC out of range");
   end

   logic [NSRC-1:0] clr_bits;
   assign clr_bits = clr_we ? clr_wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         pend_q <= '0;
      end else begin
         if (mask_we) mask_q <= mask_wdata;
         pend_q <= (pend_q & ~clr_bits) | evt;
      end
   end

   assign irq = |(pend_q & ~mask_q);

   for (genvar b = 0; b < NSRC; b++) begin : g_chk
      p_pend_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[b] && !clr_bits[b]) |=> pend_q[b]);
      p_evt_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
         evt[b] |=> pend_q[b]);
   end
   p_all_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq);
endmodule

// File: rtl/dmaq_done.sv
module dmaq_done #(
   parameter int ID_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 done_valid,
   input  logic [ID_W-1:0]      done_id,
   input  logic                 done_partial,
   input  logic                 assign_valid,
   input  logic [ID_W-1:0]      assign_id,
   input  logic                 part_clr,
   output logic [(1<<ID_W)-1:0] map_q,
   output logic                 part_q
);
   localparam int NUM_IDS = 1 << ID_W;

   logic [NUM_IDS-1:0] map_n;

   always_comb begin
      map_n = map_q;
      if (assign_valid) map_n[assign_id] = 1'b0;
      if (done_valid)   map_n[done_id]   = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q  <= '0;
         part_q <= 1'b0;
      end else begin
         map_q <= map_n;
         if (done_valid && done_partial) part_q <= 1'b1;
         else if (part_clr)              part_q <= 1'b0;
      end
   end

   p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> map_q[$past(done_id)]);
   p_reassign_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (assign_valid && !(done_valid && done_id == assign_id)) |=> !map_q[$past(assign_id)]);
   p_partial_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_partial) |=> part_q);
endmodule

// File: rtl/dma_submit_queue.sv
module dma_submit_queue
   import dmaq_pkg::*;
#(
   parameter int QDEPTH         = 4,
   parameter int LEN_W          = 24,
   parameter int LEN_ALIGN_BITS = 2,
   parameter bit HAS_2D         = 1'b1,
   parameter bit HAS_CYCLIC     = 1'b1,
   parameter bit SRC_MEM        = 1'b1,
   parameter bit DST_MEM        = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [11:0] reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        desc_valid,
   input  logic        desc_ready,
   output logic [4:0]  desc_id,
   output logic [2:0]  desc_flags,
   output logic [31:0] desc_dst,
   output logic [31:0] desc_src,
   output logic [31:0] desc_xlen,
   output logic [31:0] desc_ylen,
   output logic [31:0] desc_dstride,
   output logic [31:0] desc_sstride,
   input  logic        done_valid,
   input  logic [4:0]  done_id,
   input  logic        done_partial,
   output logic        irq
);
   localparam logic [31:0] LEN_MASK   = (LEN_W >= 32) ? 32'hFFFF_FFFF : ((32'h1 << LEN_W) - 32'h1);
   localparam logic [31:0] ALIGN_MASK = (32'h1 << LEN_ALIGN_BITS) - 32'h1;
   localparam logic [2:0]  FLAG_MASK  = {2'b11, HAS_CYCLIC};
   localparam int          DESC_W     = $bits(dmaq_desc_t);

   if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
      $error("dma_submit_queue: LEN_W out of range");
   end
   if (LEN_ALIGN_BITS >= LEN_W) begin : g_bad_align
      $error("dma_submit_queue: alignment wider than length");
   end

   // ---------------- control and staging ----------------
   logic [1:0]      ctrl_q;
   logic [2:0]      flags_q;
   logic [31:0]     xlen_q, ylen_q;
   logic [ID_W-1:0] next_id;
   logic            start_pend;
   logic            enabled, paused;

   assign enabled = ctrl_q[0];
   assign paused  = ctrl_q[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         flags_q <= '0;
         xlen_q  <= ALIGN_MASK;
      end else if (reg_we) begin
         if (reg_addr == OFF_CTRL)  ctrl_q  <= reg_wdata[1:0];
         if (reg_addr == OFF_FLAGS) flags_q <= reg_wdata[2:0] & FLAG_MASK;
         if (reg_addr == OFF_XLEN)  xlen_q  <= (reg_wdata & LEN_MASK) | ALIGN_MASK;
      end
   end

   if (HAS_2D) begin : g_2d
      always_ff @(posedge clk) begin
         if (!rst_n)                              ylen_q <= '0;
         else if (reg_we && reg_addr == OFF_YLEN) ylen_q <= reg_wdata & LEN_MASK;
      end
   end else begin : g_1d
      assign ylen_q = '0;
   end

   // side 0 = destination, side 1 = source
   for (genvar s = 0; s < 2; s++) begin : g_side
      localparam bit                IS_MEM = (s == 0) ? DST_MEM : SRC_MEM;
      localparam logic [ADDR_W-1:0] A_ADDR = (s == 0) ? OFF_DST : OFF_SRC;
      localparam logic [ADDR_W-1:0] A_STR  = (s == 0) ? OFF_DSTRIDE : OFF_SSTRIDE;
      logic [31:0] addr_q, stride_q;
      if (IS_MEM) begin : g_mm
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               addr_q   <= '0;
               stride_q <= '0;
            end else if (reg_we) begin
               if (reg_addr == A_ADDR) addr_q   <= reg_wdata;
               if (reg_addr == A_STR)  stride_q <= reg_wdata;
            end
         end
      end else begin : g_dev
         assign addr_q   = '0;
         assign stride_q = '0;
      end
   end

   // ---------------- submission ----------------
   logic       fifo_full, fifo_empty, push, pop;
   dmaq_desc_t push_d, head_d;
   logic [DESC_W-1:0] head_raw;

   assign push = start_pend && enabled && !fifo_full;

   always_ff @(posedge clk) begin
      if (!rst_n || !enabled)
         start_pend <= 1'b0;
      else if (reg_we && reg_addr == OFF_START && reg_wdata[0])
         start_pend <= 1'b1;
      else if (push)
         start_pend <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    next_id <= '0;
      else if (push) next_id <= next_id + 1'b1;
   end

   always_comb begin
      push_d.id      = next_id;
      push_d.flags   = flags_q;
      push_d.dst     = g_side[0].addr_q;
      push_d.src     = g_side[1].addr_q;
      push_d.xlen    = xlen_q;
      push_d.ylen    = ylen_q;
      push_d.dstride = g_side[0].stride_q;
      push_d.sstride = g_side[1].stride_q;
   end

   dmaq_fifo #(.DEPTH(QDEPTH), .WIDTH(DESC_W)) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!enabled),
      .push  (push),
      .wdata (push_d),
      .pop   (pop),
      .rdata (head_raw),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   assign head_d       = dmaq_desc_t'(head_raw);
   assign desc_valid   = !fifo_empty && enabled && !paused;
   assign pop          = desc_valid && desc_ready;
   assign desc_id      = head_d.id;
   assign desc_flags   = head_d.flags;
   assign desc_dst     = head_d.dst;
   assign desc_src     = head_d.src;
   assign desc_xlen    = head_d.xlen;
   assign desc_ylen    = head_d.ylen;
   assign desc_dstride = head_d.dstride;
   assign desc_sstride = head_d.sstride;

   // ---------------- completion and interrupts ----------------
   logic [NUM_IDS-1:0] done_map;
   logic               part_pend;
   logic [NUM_IRQ-1:0] irq_evt, irq_mask, irq_pend;

   dmaq_done #(.ID_W(ID_W)) i_done (
      .clk          (clk),
      .rst_n        (rst_n),
      .done_valid   (done_valid),
      .done_id      (done_id),
      .done_partial (done_partial),
      .assign_valid (push),
      .assign_id    (next_id),
      .part_clr     (reg_we && reg_addr == OFF_DONE && reg_wdata[31]),
      .map_q        (done_map),
      .part_q       (part_pend)
   );

   always_comb begin
      irq_evt             = '0;
      irq_evt[IRQ_ACCEPT] = push;
      irq_evt[IRQ_FINISH] = done_valid;
   end

   dmaq_irq #(.NSRC(NUM_IRQ)) i_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (irq_evt),
      .mask_we    (reg_we && reg_addr == OFF_MASK),
      .mask_wdata (reg_wdata[NUM_IRQ-1:0]),
      .clr_we     (reg_we && reg_addr == OFF_PEND),
      .clr_wdata  (reg_wdata[NUM_IRQ-1:0]),
      .mask_q     (irq_mask),
      .pend_q     (irq_pend),
      .irq        (irq)
   );

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFF_MASK:    reg_rdata[NUM_IRQ-1:0] = irq_mask;
         OFF_PEND:    reg_rdata[NUM_IRQ-1:0] = irq_pend;
         OFF_ACTIVE:  reg_rdata[NUM_IRQ-1:0] = irq_pend & ~irq_mask;
         OFF_CTRL:    reg_rdata[1:0]         = ctrl_q;
         OFF_NEXTID:  reg_rdata[ID_W-1:0]    = next_id;
         OFF_START:   reg_rdata[0]           = start_pend;
         OFF_FLAGS:   reg_rdata[2:0]         = flags_q;
         OFF_DST:     reg_rdata              = g_side[0].addr_q;
         OFF_SRC:     reg_rdata              = g_side[1].addr_q;
         OFF_XLEN:    reg_rdata              = xlen_q;
         OFF_YLEN:    reg_rdata              = ylen_q;
         OFF_DSTRIDE: reg_rdata              = g_side[0].stride_q;
         OFF_SSTRIDE: reg_rdata              = g_side[1].stride_q;
         OFF_DONE:    reg_rdata              = {done_map[31] | part_pend, done_map[30:0]};
         default:     reg_rdata              = '0;
      endcase
   end

   // ---------------- assertions ----------------
   p_valid_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> (enabled && !paused));
   p_id_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> next_id == $past(next_id) + 1'b1);
   p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |=> !desc_valid);
   p_start_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pend && enabled && fifo_full && !pop) |=> start_pend);
   p_off_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |=> $stable(next_id));
endmodule

// File: tb/test_dma_submit_queue.sv
module test_dma_submit_queue;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        desc_valid, desc_ready = 1'b0;
   logic [4:0]  desc_id;
   logic [2:0]  desc_flags;
   logic [31:0] desc_dst, desc_src, desc_xlen, desc_ylen, desc_dstride, desc_sstride;
   logic        done_valid = 1'b0;
   logic [4:0]  done_id = '0;
   logic        done_partial = 1'b0;
   logic        irq;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dma_submit_queue i_dma_submit_queue (.*);

   localparam logic [11:0] MASK = 12'h080, PEND = 12'h084, ACTV = 12'h088,
      CTRL = 12'h400, NXID = 12'h404, STRT = 12'h408, FLGS = 12'h40c,
      DSTA = 12'h410, SRCA = 12'h414, XLEN = 12'h418, YLEN = 12'h41c,
      DSTR = 12'h420, SSTR = 12'h424, DONE = 12'h428;

   // {address, write data, expected readback}
   localparam logic [31:0] VEC [10][3] = '{
      '{32'h40c, 32'h0000_0007, 32'h0000_0007},  // R2 flags
      '{32'h418, 32'hFFFF_FFFF, 32'h00FF_FFFF},  // R2 max length
      '{32'h418, 32'h0000_0000, 32'h0000_0003},  // R2 alignment mask
      '{32'h418, 32'h0000_1234, 32'h0000_1237},  // R2 forced low ones
      '{32'h41c, 32'hFF00_0009, 32'h0000_0009},  // R2 y length width
      '{32'h414, 32'h8000_1000, 32'h8000_1000},  // R2 source address
      '{32'h424, 32'h0000_0080, 32'h0000_0080},  // R2 source stride
      '{32'h410, 32'h0000_ABCD, 32'h0000_0000},  // R3 device-side address
      '{32'h420, 32'h0000_0040, 32'h0000_0000},  // R3 device-side stride
      '{32'h400, 32'h0000_0002, 32'h0000_0002}   // R6 pause bit readback
   };

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rdchk(string tag, logic [11:0] a, logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic submit();
      wr(STRT, 32'h1);
      @(negedge clk);
   endtask

   task automatic report_done(logic [4:0] id, logic part);
      @(negedge clk);
      done_valid = 1'b1; done_id = id; done_partial = part;
      @(negedge clk);
      done_valid = 1'b0; done_partial = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rdchk("R1 ctrl", CTRL, 0);
      rdchk("R1 next id", NXID, 0);
      rdchk("R1 mask", MASK, 3);
      rdchk("R1 pending", PEND, 0);
      rdchk("R1 done", DONE, 0);
      rdchk("R1 xlen", XLEN, 3);
      check("R1 desc_valid", {31'b0, desc_valid}, 0);
      check("R1 irq", {31'b0, irq}, 0);

      // register table
      for (int i = 0; i < 10; i++) begin
         wr(VEC[i][0][11:0], VEC[i][1]);
         rdchk("R2 R3 staging readback", VEC[i][0][11:0], VEC[i][2]);
      end

      // R11 start while disabled
      wr(CTRL, 0);
      submit();
      rdchk("R11 start ignored", STRT, 0);
      rdchk("R11 id unchanged", NXID, 0);
      check("R11 nothing offered", {31'b0, desc_valid}, 0);

      // R4 first submission
      wr(CTRL, 1);
      wr(FLGS, 2); wr(SRCA, 32'h100); wr(XLEN, 32'h3F); wr(YLEN, 1); wr(DSTA, 32'h55);
      submit();
      check("R4 valid", {31'b0, desc_valid}, 1);
      check("R4 id", {27'b0, desc_id}, 0);
      check("R4 src", desc_src, 32'h100);
      check("R4 xlen", desc_xlen, 32'h3F);
      check("R4 ylen", desc_ylen, 1);
      check("R4 flags", {29'b0, desc_flags}, 2);
      check("R3 dst port", desc_dst, 0);
      check("R4 sstride", desc_sstride, 32'h80);
      rdchk("R4 next id", NXID, 1);
      rdchk("R9 accept pending", PEND, 1);
      check("R10 masked irq", {31'b0, irq}, 0);

      // R5 fill queue
      for (int k = 1; k < 4; k++) begin
         wr(SRCA, 32'h100 * (k + 1));
         submit();
      end
      wr(SRCA, 32'h500);
      wr(STRT, 1);
      rdchk("R5 busy while full", STRT, 1);
      rdchk("R5 id held", NXID, 4);
      @(negedge clk);
      rdchk("R5 still busy", STRT, 1);
      desc_ready = 1'b1;
      @(negedge clk);
      desc_ready = 1'b0;
      check("R4 order head", {27'b0, desc_id}, 1);
      check("R4 order src", desc_src, 32'h200);
      @(negedge clk);
      rdchk("R5 accepted after pop", STRT, 0);
      rdchk("R5 id after accept", NXID, 5);

      // R6 pause
      wr(CTRL, 3);
      check("R6 paused", {31'b0, desc_valid}, 0);
      wr(CTRL, 1);
      check("R6 resumed", {31'b0, desc_valid}, 1);
      check("R6 kept head", {27'b0, desc_id}, 1);
      desc_ready = 1'b1;
      for (int k = 1; k < 5; k++) begin
         check("R4 drain order", {27'b0, desc_id}, k);
         @(negedge clk);
      end
      desc_ready = 1'b0;
      check("R4 drained", {31'b0, desc_valid}, 0);

      // R7 disable drops queue
      submit();
      submit();
      check("R7 queued", {31'b0, desc_valid}, 1);
      wr(CTRL, 0);
      check("R7 off", {31'b0, desc_valid}, 0);
      wr(CTRL, 1);
      @(negedge clk);
      check("R7 dropped", {31'b0, desc_valid}, 0);
      rdchk("R7 id kept", NXID, 7);

      // R8 completion
      report_done(3, 0);
      rdchk("R8 done bit", DONE, 32'h8);
      rdchk("R9 finish pending", PEND, 3);
      report_done(5, 1);
      rdchk("R8 partial flag", DONE, 32'h8000_0028);
      wr(DONE, 32'h8000_0000);
      rdchk("R8 partial cleared", DONE, 32'h28);
      desc_ready = 1'b1;
      for (int k = 0; k < 25; k++) submit();
      rdchk("R4 id wrap", NXID, 0);
      for (int k = 0; k < 3; k++) submit();
      rdchk("R8 bit kept", DONE, 32'h28);
      submit();
      rdchk("R8 cleared on reuse", DONE, 32'h20);
      desc_ready = 1'b0;

      // R9 R10 interrupts
      wr(MASK, 1);
      check("R10 unmasked finish", {31'b0, irq}, 1);
      rdchk("R10 active", ACTV, 2);
      wr(PEND, 2);
      rdchk("R9 clear", PEND, 1);
      check("R10 irq low", {31'b0, irq}, 0);
      wr(MASK, 0);
      check("R10 accept irq", {31'b0, irq}, 1);
      wr(PEND, 1);
      check("R9 all clear", {31'b0, irq}, 0);
      @(negedge clk);
      reg_addr = PEND; reg_wdata = 2; reg_we = 1'b1;
      done_valid = 1'b1; done_id = 9;
      @(negedge clk);
      reg_we = 1'b0; done_valid = 1'b0;
      rdchk("R9 set wins", PEND, 2);
      check("R10 irq from finish", {31'b0, irq}, 1);

      finish_run();
   end
endmodule